// File: doc/BRIEF.md
# Repeated-Pattern Classifier and Frequency Counter

This block gathers a buffer of 16-bit words and sorts them into classes of identical values. It works in successive passes. Each pass takes the earliest word that no earlier class has claimed and uses it as the pass pattern. The pass then sweeps the whole buffer one word per clock. Every unclaimed word equal to the pattern is claimed and counted, and this includes the seeding word itself. When no unclaimed word is left, the block streams out one pattern/count pair per class, in the order the classes were found.

Software or an upstream stage appends words through a simple load strobe while the block is idle. It then pulses `start` and collects the pairs from a valid/ready stream. A later stage can use these pairs to build a variable-length code. A one-cycle `done` pulse closes every run and empties the load buffer for the next batch.

Top module: `rpt_classifier`

## Requirements
- R1: After reset `busy`, `done` and `res_valid` are low.
- R2: Each distinct value among the loaded words is emitted exactly once, and the pairs come out in the order in which each value first appears in the buffer (buffer position 0 is the first loaded word).
- R3: The count in each pair (`res_count`, unsigned) equals the number of loaded words holding that pattern, the seeding word included; counts therefore lie in 1..64 and add up to the number of loaded words.
- R4: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_pattern` and `res_count` hold their values into the next cycle.
- R5: `done` is high for exactly one cycle, the cycle right after the last pair is accepted. In that cycle `busy` and `res_valid` are low.
- R6: A `start` pulse while `busy` is high is ignored: the emitted pairs and the result latency do not change.
- R7: A `start` with no words loaded raises `done` in the following cycle and emits no pair.
- R8: `busy` is high in the cycle after `start` is accepted. With N loaded words forming P classes, the first pair becomes valid P*(N+1)+1 clock edges after the edge that samples `start`, because each pass costs N scan cycles plus one search cycle.
- R9: A high `ld_en` while idle appends `ld_word` to the buffer. Words beyond the 64th are dropped, words offered while `busy` is high are dropped, and the buffer is empty again after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Append `ld_word` to the buffer (idle only) |
| ld_word | input | 16 | Word to append |
| start | input | 1 | Begin classifying the loaded buffer |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| res_valid | output | 1 | A pattern/count pair is offered |
| res_ready | input | 1 | Consumer accepts the offered pair |
| res_pattern | output | 16 | Class pattern |
| res_count | output | 7 | Occurrences of the pattern |

## Verification
A claim flag that is wrongly left set, or never set, either drops a class or emits one value twice, and it also shifts every count after it. This shows up in the first pair after the faulty pass. A scan counter that stops one word early or late changes the counts and also the start-to-first-valid latency by P cycles, so the latency check catches it before any pair is read. Faults in the output queue pointers appear as held data that changes under back-pressure, or as a `done` pulse in the wrong cycle at the end of the stream.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned DEPTH  = 64;
    localparam int unsigned IDX_W  = $clog2(DEPTH);
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        word_t pattern;
        cnt_t  count;
    } pair_t;

    typedef struct packed {
        logic found;
        idx_t idx;
    } seek_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEEK = 2'd1,
        PH_SCAN = 2'd2,
        PH_EMIT = 2'd3
    } phase_e;

    // Lowest set position of a mask: the earliest unclaimed buffer word.
    function automatic seek_t find_first(input logic [DEPTH-1:0] open_mask);
        seek_t r;
        r = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (open_mask[i]) begin
                r.found = 1'b1;
                r.idx   = idx_t'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rpt_word_buf.sv
module rpt_word_buf
    import rpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_ok,
    input  logic  ld_en,
    input  word_t ld_word,
    input  logic  restart,
    input  logic  fill_clr,
    input  idx_t  rd_idx,
    input  logic  mark_en,
    output word_t rd_word,
    output logic  rd_matched,
    output cnt_t  fill,
    output seek_t seek
);

    word_t            mem [DEPTH];
    logic [DEPTH-1:0] claimed;
    logic [DEPTH-1:0] live;
    logic             wr_fire;

    assign wr_fire = load_ok && ld_en && (fill < cnt_t'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[fill[IDX_W-1:0]] <= ld_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || fill_clr) begin
            fill <= '0;
        end else if (wr_fire) begin
            fill <= fill + cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            claimed <= '0;
        end else if (mark_en) begin
            claimed[rd_idx] <= 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_live
        assign live[g] = (cnt_t'(g) < fill);
    end

    assign seek       = find_first(live & ~claimed);
    assign rd_word    = mem[rd_idx];
    assign rd_matched = claimed[rd_idx];

endmodule

// File: rtl/rpt_scan_ctrl.sv
module rpt_scan_ctrl
    import rpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  cnt_t  fill,
    input  seek_t seek,
    input  word_t rd_word,
    input  logic  rd_matched,
    input  logic  last_take,
    output idx_t  rd_idx,
    output logic  mark_en,
    output logic  restart,
    output logic  fill_clr,
    output logic  load_ok,
    output logic  push,
    output pair_t push_pair,
    output logic  emit_en,
    output logic  busy,
    output logic  done
);

    phase_e phase;
    cnt_t   n_words;
    word_t  pattern;
    cnt_t   hits;
    idx_t   scan_idx;

    logic   hit;
    logic   end_pass;
    logic   take_start;
    cnt_t   tally;

    always_comb begin
        rd_idx     = (phase == PH_SEEK) ? seek.idx : scan_idx;
        hit        = (phase == PH_SCAN) && !rd_matched && (rd_word == pattern);
        end_pass   = (cnt_t'(scan_idx) + cnt_t'(1)) == n_words;
        tally      = hits + cnt_t'(hit);
        take_start = (phase == PH_IDLE) && start;
        mark_en    = hit;
        restart    = take_start;
        fill_clr   = (take_start && (fill == '0)) ||
                     ((phase == PH_EMIT) && last_take);
        push       = (phase == PH_SCAN) && end_pass;
        push_pair  = '{pattern: pattern, count: tally};
        load_ok    = (phase == PH_IDLE);
        emit_en    = (phase == PH_EMIT);
        busy       = (phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            n_words  <= '0;
            pattern  <= '0;
            hits     <= '0;
            scan_idx <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (fill == '0) begin
                            done <= 1'b1;
                        end else begin
                            n_words <= fill;
                            phase   <= PH_SEEK;
                        end
                    end
                end
                PH_SEEK: begin
                    if (seek.found) begin
                        pattern  <= rd_word;
                        hits     <= '0;
                        scan_idx <= '0;
                        phase    <= PH_SCAN;
                    end else begin
                        phase <= PH_EMIT;
                    end
                end
                PH_SCAN: begin
                    hits <= tally;
                    if (end_pass) begin
                        phase <= PH_SEEK;
                    end else begin
                        scan_idx <= scan_idx + idx_t'(1);
                    end
                end
                PH_EMIT: begin
                    if (last_take) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rpt_result_q.sv
module rpt_result_q
    import rpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  push,
    input  pair_t push_pair,
    input  logic  emit_en,
    input  logic  out_ready,
    output logic  out_valid,
    output pair_t out_pair,
    output logic  last_take
);

    pair_t mem [DEPTH];
    cnt_t  wr_ptr;
    cnt_t  rd_ptr;
    logic  take;

    assign out_valid = emit_en && (rd_ptr != wr_ptr);
    assign out_pair  = mem[rd_ptr[IDX_W-1:0]];
    assign take      = out_valid && out_ready;
    assign last_take = take && ((rd_ptr + cnt_t'(1)) == wr_ptr);

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr[IDX_W-1:0]] <= push_pair;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + cnt_t'(1);
            end
            if (take) begin
                rd_ptr <= rd_ptr + cnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/rpt_classifier.sv
module rpt_classifier
    import rpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [WORD_W-1:0] res_pattern,
    output logic [CNT_W-1:0]  res_count
);

    word_t rd_word;
    logic  rd_matched;
    cnt_t  fill;
    seek_t seek;
    idx_t  rd_idx;
    logic  mark_en;
    logic  restart;
    logic  fill_clr;
    logic  load_ok;
    logic  push;
    pair_t push_pair;
    logic  emit_en;
    logic  last_take;
    pair_t out_pair;

    rpt_word_buf u_buf (
        .clk        (clk),
        .rst        (rst),
        .load_ok    (load_ok),
        .ld_en      (ld_en),
        .ld_word    (ld_word),
        .restart    (restart),
        .fill_clr   (fill_clr),
        .rd_idx     (rd_idx),
        .mark_en    (mark_en),
        .rd_word    (rd_word),
        .rd_matched (rd_matched),
        .fill       (fill),
        .seek       (seek)
    );

    rpt_scan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .fill       (fill),
        .seek       (seek),
        .rd_word    (rd_word),
        .rd_matched (rd_matched),
        .last_take  (last_take),
        .rd_idx     (rd_idx),
        .mark_en    (mark_en),
        .restart    (restart),
        .fill_clr   (fill_clr),
        .load_ok    (load_ok),
        .push       (push),
        .push_pair  (push_pair),
        .emit_en    (emit_en),
        .busy       (busy),
        .done       (done)
    );

    rpt_result_q u_q (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .push      (push),
        .push_pair (push_pair),
        .emit_en   (emit_en),
        .out_ready (res_ready),
        .out_valid (res_valid),
        .out_pair  (out_pair),
        .last_take (last_take)
    );

    assign res_pattern = out_pair.pattern;
    assign res_count   = out_pair.count;

endmodule

// File: rtl/rpt_classifier_chk.sv
module rpt_classifier_chk
    import rpt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              res_valid,
    input logic              res_ready,
    input logic [WORD_W-1:0] res_pattern,
    input logic [CNT_W-1:0]  res_count
);

    // R1: nothing is offered outside a run
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !res_valid);

    // R2: consecutive accepted classes never repeat a pattern
    a_r2_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ready) |=> !(res_valid && (res_pattern == $past(res_pattern))));

    // R3: a class holds at least its seed and at most the full buffer
    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_count != '0) && (res_count <= CNT_W'(DEPTH))));

    // R4: back-pressure freezes the offered pair
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_pattern) && $stable(res_count)));

    // R5: done is a single-cycle pulse
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: done arrives with the run closed and the stream empty
    a_r5_done_closed: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !res_valid));

    // R6/R8: a run only begins on a start request
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

bind rpt_classifier rpt_classifier_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_pattern (res_pattern),
    .res_count   (res_count)
);

// File: tb/rpt_classifier_tb_top.sv
module rpt_classifier_tb_top;
    import rpt_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              ld_en;
    logic [WORD_W-1:0] ld_word;
    logic              start;
    logic              busy;
    logic              done;
    logic              res_valid;
    logic              res_ready;
    logic [WORD_W-1:0] res_pattern;
    logic [CNT_W-1:0]  res_count;

    always #5 clk = ~clk;

    rpt_classifier dut_i (
        .clk         (clk),
        .rst         (rst),
        .ld_en       (ld_en),
        .ld_word     (ld_word),
        .start       (start),
        .busy        (busy),
        .done        (done),
        .res_valid   (res_valid),
        .res_ready   (res_ready),
        .res_pattern (res_pattern),
        .res_count   (res_count)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Stimulus table: length, value alphabet (0 = all distinct), ready stall period,
    // mid-run start/load poke, generator seed.
    localparam int N_CASES = 7;
    localparam int CASE_LEN   [N_CASES] = '{1, 5, 16, 40, 64, 70, 33};
    localparam int CASE_ALPHA [N_CASES] = '{1, 1, 3, 8, 0, 5, 2};
    localparam int CASE_STALL [N_CASES] = '{0, 2, 2, 3, 0, 4, 3};
    localparam bit CASE_POKE  [N_CASES] = '{0, 0, 0, 1, 0, 0, 1};
    localparam int CASE_SEED  [N_CASES] = '{3, 11, 29, 47, 5, 71, 97};

    int exp_pat [DEPTH];
    int exp_cnt [DEPTH];
    int words   [80];
    int exp_n;
    int used_n;

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Build a buffer and the expected classes by the first-unclaimed-first procedure.
    task automatic build(input int c);
        int unsigned s;
        bit taken [DEPTH];
        s = CASE_SEED[c];
        for (int i = 0; i < CASE_LEN[c]; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            if (CASE_ALPHA[c] == 0) words[i] = (i * 37 + 5) & 16'hFFFF;
            else words[i] = 16'h4C00 + int'((s >> 16) % CASE_ALPHA[c]);
        end
        used_n = (CASE_LEN[c] > DEPTH) ? DEPTH : CASE_LEN[c];
        for (int i = 0; i < DEPTH; i++) taken[i] = 0;
        exp_n = 0;
        for (int i = 0; i < used_n; i++) begin
            if (!taken[i]) begin
                exp_pat[exp_n] = words[i];
                exp_cnt[exp_n] = 0;
                for (int j = 0; j < used_n; j++) begin
                    if (!taken[j] && words[j] == words[i]) begin
                        taken[j] = 1;
                        exp_cnt[exp_n]++;
                    end
                end
                exp_n++;
            end
        end
    endtask

    task automatic run_case(input int c);
        int lat;
        int k;
        int cyc;
        bit rdy;
        bit pv;
        bit prdy;
        int pp;
        int pc;
        build(c);
        for (int i = 0; i < CASE_LEN[c]; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_word = words[i][15:0];
        end
        @(negedge clk);
        ld_en     = 1'b0;
        res_ready = 1'b1;
        start     = 1'b1;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (lat == 1) check(busy == 1'b1, "R8 busy after start", busy, 1);
            start = 1'b0;
            ld_en = 1'b0;
            if (CASE_POKE[c] && lat == 3) begin
                start   = 1'b1;        // R6: ignored while busy
                ld_en   = 1'b1;        // R9: dropped while busy
                ld_word = 16'hBEEF;
            end
            if (res_valid) break;
        end
        start = 1'b0;
        ld_en = 1'b0;
        check(lat == exp_n * (used_n + 1) + 2, "R8 latency (R6 when poked)", lat,
              exp_n * (used_n + 1) + 2);
        k = 0; cyc = 0; pv = 0; prdy = 1; pp = 0; pc = 0;
        forever begin
            rdy = (CASE_STALL[c] == 0) ? 1'b1 : ((cyc % CASE_STALL[c]) != 0);
            res_ready = rdy;
            if (pv && !prdy)
                check(res_valid && int'(res_pattern) == pp && int'(res_count) == pc,
                      "R4 hold", int'(res_pattern), pp);
            if (res_valid && rdy) begin
                check(int'(res_pattern) == exp_pat[k], "R2 pattern order", int'(res_pattern), exp_pat[k]);
                check(int'(res_count) == exp_cnt[k], "R3 count", int'(res_count), exp_cnt[k]);
                k++;
            end
            pv = res_valid; prdy = rdy; pp = int'(res_pattern); pc = int'(res_count);
            if (k == exp_n) break;
            @(negedge clk);
            cyc++;
        end
        res_ready = 1'b1;
        @(negedge clk);
        check(done == 1'b1, "R5 done after last", done, 1);
        check(res_valid == 1'b0 && busy == 1'b0, "R5 closed at done", {res_valid, busy}, 0);
        @(negedge clk);
        check(done == 1'b0, "R5 done single", done, 0);
    endtask

    task automatic empty_start(input string tag);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && res_valid == 1'b0, tag, {done, res_valid}, 2);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, tag, {done, busy}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst = 1'b1; ld_en = 1'b0; ld_word = '0; start = 1'b0; res_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && res_valid == 1'b0, "R1 reset state",
              {busy, done, res_valid}, 0);
        empty_start("R7 empty buffer");
        for (int c = 0; c < N_CASES; c++) run_case(c);
        // buffer must be empty after done; the word offered while busy was dropped
        empty_start("R9 buffer cleared and busy load dropped (R7)");
        report();
    end

endmodule